// File: doc/BRIEF.md
# Link Training Sequencer

This block sits in the controller of a graphics DRAM channel. After power-up it runs the interface training steps in a fixed order. Address training comes first and can be turned off. Next it aligns the write clock to the command clock, then trains read data, and finally trains write data. In each step it moves a phase code from 0 upward, waits a programmable settle time at each code, and then judges the point. For the clock step it samples a static early/late flag. For the data steps it issues a command through a request/acknowledge handshake and samples a pass/fail result. Every trained setting is held on a dedicated output.

The clock step locks on the first code at which the flag reads late right after an early reading. Each data step records the first and the last passing codes over the whole sweep and keeps their midpoint. If a step finds no valid setting, the sequencer stops with an error flag. Read training preloads the read FIFO once and then reads it back at every code. Write training writes the FIFO and reads it back at every code.

Once training is complete, a retrain request is acted on only while a refresh window is open. A retrain normally starts at read training. It starts at clock alignment when a frequency-change flag is set. A start pulse always begins the full sequence.

Top module: `link_train_seq`

## Requirements
- R1: After reset, done, error and cmdReq are 0, stepId is 0 and all four trained phase outputs are 0.
- R2: stepId encodes the running step as 1 address, 2 clock alignment, 3 read, 4 write, and 0 when nothing runs. A start runs the steps in the order 1, 2, 3, 4. Step 1 is left out, and addrPhase is left unchanged, when cfgAddrEn is 0.
- R3: Clock alignment commits the first phase code at which lateFlag reads 1 while the previous code read 0. If no such code exists in the range 0 to 63, the sequence fails.
- R4: Each data step sweeps every code from 0 to 63. It commits floor((first passing code + last passing code) / 2) to its output.
- R5: A step with no valid setting sets error, stops at that step and issues no further command until the next start.
- R6: cmdKind encodes 0 address capture, 1 FIFO preload, 2 FIFO read and 3 FIFO write. Address training issues one capture per code. Read training issues one preload and then one FIFO read per code. Write training issues a FIFO write and then a FIFO read per code. The pass result is taken on the acknowledge of the last command for that code.
- R7: phaseIdx holds steady for at least cfgSettle+1 cycles before the first command (other than the preload) or flag sample at that code.
- R8: done rises only after write training succeeds, and it stays high until the next start or retrain.
- R9: While done is high, retrainReq is acted on only when refreshWin is high. The retrain starts at step 3, or at step 2 when freqChange is 1. Steps that are not rerun keep their outputs.
- R10: start and retrainReq in the same cycle run the full sequence from the first step. A start also clears error.
- R11: Once raised, cmdReq stays high, and cmdKind and phaseIdx stay constant, until cmdAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin the full training sequence |
| cfgAddrEn | input | 1 | Include the address training step |
| cfgSettle | input | SETTLE_W | Settle cycles per code, minus one |
| retrainReq | input | 1 | Request periodic retraining |
| freqChange | input | 1 | Retrain from clock alignment |
| refreshWin | input | 1 | Refresh window open |
| cmdReq | output | 1 | Training command request |
| cmdKind | output | 2 | Training command type |
| cmdAck | input | 1 | Command completed, result valid |
| resultPass | input | 1 | Compare result of the command |
| lateFlag | input | 1 | Clock phase reads late |
| phaseIdx | output | PHASE_W | Phase code under test |
| stepId | output | 3 | Running step |
| addrPhase | output | PHASE_W | Trained address phase |
| wckPhase | output | PHASE_W | Trained clock phase |
| readPhase | output | PHASE_W | Trained read capture phase |
| writePhase | output | PHASE_W | Trained write data phase |
| done | output | 1 | Training complete |
| error | output | 1 | Training failed |

## Verification
Two requests can meet in one cycle while training is complete: a start and a retrain request. One runs the full sequence and the other runs a partial one. The bench raises both together, with the refresh window open, and records the order of stepId values that follows. It expects the full order beginning at address training. A second collision occurs within each sweep point, where the acknowledge of the last command at a code also carries that code's result. The bench's device model makes the pass window end exactly at code 0 or code 63. The committed midpoints show whether the result was taken on the right acknowledge.

// File: rtl/lts_pkg.sv
package lts_pkg;

  typedef enum logic [2:0] {
    STEP_NONE  = 3'd0,
    STEP_ADDR  = 3'd1,
    STEP_WCK   = 3'd2,
    STEP_READ  = 3'd3,
    STEP_WRITE = 3'd4
  } step_e;

  typedef enum logic [1:0] {
    CMD_ADDR_CAP   = 2'd0,
    CMD_FIFO_LOAD  = 2'd1,
    CMD_FIFO_READ  = 2'd2,
    CMD_FIFO_WRITE = 2'd3
  } cmd_e;

  typedef struct packed {
    logic clrSweep;
    logic armSettle;
    logic incIdx;
    logic samplePass;
    logic sampleLate;
    logic commit;
  } strobe_t;

endpackage

// File: rtl/lts_ctrl.sv
module lts_ctrl
  import lts_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    cfgAddrEn,
  input  logic    retrainReq,
  input  logic    freqChange,
  input  logic    refreshWin,
  input  logic    cmdAck,
  input  logic    settleDone,
  input  logic    lastIdx,
  input  logic    found,
  input  logic    edgeNow,
  output strobe_t strb,
  output step_e   curStep,
  output logic    cmdReq,
  output logic [1:0] cmdKind,
  output logic [2:0] stepId,
  output logic    done,
  output logic    error
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETTLE, S_ISSUE, S_EVAL, S_NEXT, S_DONE, S_FAIL
  } state_e;

  state_e state, nState;
  step_e  nStep, launchStep, firstStep;
  logic   wrSub, nWrSub, launch;
  cmd_e   kindSel;

  always_comb begin
    strb       = '0;
    nState     = state;
    nStep      = curStep;
    nWrSub     = wrSub;
    cmdReq     = 1'b0;
    kindSel    = CMD_ADDR_CAP;
    launch     = 1'b0;
    launchStep = STEP_NONE;
    firstStep  = cfgAddrEn ? STEP_ADDR : STEP_WCK;
    case (state)
      S_IDLE: begin
        if (start) begin
          launch = 1'b1;
          launchStep = firstStep;
        end
      end
      S_LOAD: begin
        cmdReq  = 1'b1;
        kindSel = CMD_FIFO_LOAD;
        if (cmdAck) begin
          strb.armSettle = 1'b1;
          nState = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (settleDone) begin
          nWrSub = 1'b0;
          nState = (curStep == STEP_WCK) ? S_EVAL : S_ISSUE;
        end
      end
      S_ISSUE: begin
        cmdReq = 1'b1;
        if (curStep == STEP_ADDR)       kindSel = CMD_ADDR_CAP;
        else if (curStep == STEP_WRITE) kindSel = wrSub ? CMD_FIFO_READ : CMD_FIFO_WRITE;
        else                            kindSel = CMD_FIFO_READ;
        if (cmdAck) begin
          if (curStep == STEP_WRITE && !wrSub) begin
            nWrSub = 1'b1;
          end else begin
            strb.samplePass = 1'b1;
            nState = S_NEXT;
          end
        end
      end
      S_EVAL: begin
        if (edgeNow) begin
          strb.commit = 1'b1;
          launch = 1'b1;
          launchStep = STEP_READ;
        end else if (lastIdx) begin
          nState = S_FAIL;
        end else begin
          strb.sampleLate = 1'b1;
          strb.incIdx     = 1'b1;
          strb.armSettle  = 1'b1;
          nState = S_SETTLE;
        end
      end
      S_NEXT: begin
        if (lastIdx) begin
          if (found) begin
            strb.commit = 1'b1;
            if (curStep == STEP_WRITE) begin
              nState = S_DONE;
            end else begin
              launch = 1'b1;
              launchStep = (curStep == STEP_ADDR) ? STEP_WCK : STEP_WRITE;
            end
          end else begin
            nState = S_FAIL;
          end
        end else begin
          strb.incIdx    = 1'b1;
          strb.armSettle = 1'b1;
          nState = S_SETTLE;
        end
      end
      S_DONE: begin
        if (start) begin
          launch = 1'b1;
          launchStep = firstStep;
        end else if (retrainReq && refreshWin) begin
          launch = 1'b1;
          launchStep = freqChange ? STEP_WCK : STEP_READ;
        end
      end
      S_FAIL: begin
        if (start) begin
          launch = 1'b1;
          launchStep = firstStep;
        end
      end
      default: nState = S_IDLE;
    endcase
    if (launch) begin
      nStep = launchStep;
      strb.clrSweep = 1'b1;
      if (launchStep == STEP_READ) begin
        nState = S_LOAD;
      end else begin
        nState = S_SETTLE;
        strb.armSettle = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      curStep <= STEP_NONE;
      wrSub   <= 1'b0;
    end else begin
      state   <= nState;
      curStep <= nStep;
      wrSub   <= nWrSub;
    end
  end

  assign cmdKind = kindSel;
  assign done    = (state == S_DONE);
  assign error   = (state == S_FAIL);
  assign stepId  = (state == S_IDLE || state == S_DONE || state == S_FAIL) ? 3'd0 : curStep;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmdReq && !cmdAck |=> cmdReq);  // R11
  AST_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmdReq && !cmdAck |=> $stable(cmdKind));  // R11
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(curStep) == STEP_WRITE);  // R8
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error && !cmdReq);  // R5

endmodule

// File: rtl/lts_datapath.sv
module lts_datapath
  import lts_pkg::*;
#(
  parameter int PHASE_W  = 6,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strb,
  input  step_e               curStep,
  input  logic [SETTLE_W-1:0] cfgSettle,
  input  logic                resultPass,
  input  logic                lateFlag,
  output logic [PHASE_W-1:0]  phaseIdx,
  output logic                settleDone,
  output logic                lastIdx,
  output logic                found,
  output logic                edgeNow,
  output logic [PHASE_W-1:0]  addrPhase,
  output logic [PHASE_W-1:0]  wckPhase,
  output logic [PHASE_W-1:0]  readPhase,
  output logic [PHASE_W-1:0]  writePhase
);

  localparam int NUM_RES = 4;
  localparam int SUM_W   = PHASE_W + 1;

  logic [PHASE_W-1:0]  firstPass, lastPass, commitVal;
  logic [SUM_W-1:0]    winSum;
  logic [SETTLE_W-1:0] settleCnt;
  logic                havePrev, prevLate;
  logic [PHASE_W-1:0]  resPhase [NUM_RES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseIdx  <= '0;
      found     <= 1'b0;
      firstPass <= '0;
      lastPass  <= '0;
      havePrev  <= 1'b0;
      prevLate  <= 1'b0;
    end else if (strb.clrSweep) begin
      phaseIdx  <= '0;
      found     <= 1'b0;
      firstPass <= '0;
      lastPass  <= '0;
      havePrev  <= 1'b0;
      prevLate  <= 1'b0;
    end else begin
      if (strb.incIdx) phaseIdx <= phaseIdx + 1'b1;
      if (strb.samplePass && resultPass) begin
        if (!found) firstPass <= phaseIdx;
        lastPass <= phaseIdx;
        found    <= 1'b1;
      end
      if (strb.sampleLate) begin
        prevLate <= lateFlag;
        havePrev <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                settleCnt <= '0;
    else if (strb.armSettle)   settleCnt <= cfgSettle;
    else if (settleCnt != '0)  settleCnt <= settleCnt - 1'b1;
  end

  assign settleDone = (settleCnt == '0);
  assign lastIdx    = &phaseIdx;
  assign edgeNow    = lateFlag && havePrev && !prevLate;
  assign winSum     = {1'b0, firstPass} + {1'b0, lastPass};
  assign commitVal  = (curStep == STEP_WCK) ? phaseIdx : winSum[SUM_W-1:1];

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    localparam step_e OWN_STEP = step_e'(3'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 resPhase[g] <= '0;
      else if (strb.commit && curStep == OWN_STEP) resPhase[g] <= commitVal;
    end
  end

  assign addrPhase  = resPhase[0];
  assign wckPhase   = resPhase[1];
  assign readPhase  = resPhase[2];
  assign writePhase = resPhase[3];

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    settleCnt != '0 |=> $stable(phaseIdx));  // R7
  AST_WINDOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> firstPass <= lastPass);  // R4
  AST_COMMIT_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit && curStep != STEP_WCK |-> found);  // R5

endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lts_pkg::*;
#(
  parameter int PHASE_W  = 6,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cfgAddrEn,
  input  logic [SETTLE_W-1:0] cfgSettle,
  input  logic                retrainReq,
  input  logic                freqChange,
  input  logic                refreshWin,
  output logic                cmdReq,
  output logic [1:0]          cmdKind,
  input  logic                cmdAck,
  input  logic                resultPass,
  input  logic                lateFlag,
  output logic [PHASE_W-1:0]  phaseIdx,
  output logic [2:0]          stepId,
  output logic [PHASE_W-1:0]  addrPhase,
  output logic [PHASE_W-1:0]  wckPhase,
  output logic [PHASE_W-1:0]  readPhase,
  output logic [PHASE_W-1:0]  writePhase,
  output logic                done,
  output logic                error
);

  strobe_t strb;
  step_e   curStep;
  logic    settleDone, lastIdx, found, edgeNow;

  lts_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfgAddrEn(cfgAddrEn),
    .retrainReq(retrainReq), .freqChange(freqChange), .refreshWin(refreshWin),
    .cmdAck(cmdAck), .settleDone(settleDone), .lastIdx(lastIdx), .found(found),
    .edgeNow(edgeNow), .strb(strb), .curStep(curStep), .cmdReq(cmdReq),
    .cmdKind(cmdKind), .stepId(stepId), .done(done), .error(error)
  );

  lts_datapath #(.PHASE_W(PHASE_W), .SETTLE_W(SETTLE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .curStep(curStep), .cfgSettle(cfgSettle),
    .resultPass(resultPass), .lateFlag(lateFlag), .phaseIdx(phaseIdx),
    .settleDone(settleDone), .lastIdx(lastIdx), .found(found), .edgeNow(edgeNow),
    .addrPhase(addrPhase), .wckPhase(wckPhase), .readPhase(readPhase),
    .writePhase(writePhase)
  );

endmodule

// File: tb/link_train_seq_test.sv
module link_train_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cfgAddrEn = 1'b0, retrainReq = 1'b0, freqChange = 1'b0, refreshWin = 1'b0;
  logic [7:0] cfgSettle = 8'd0;
  logic cmdReq, cmdAck, resultPass, lateFlag, done, error;
  logic [1:0] cmdKind;
  logic [5:0] phaseIdx, addrPhase, wckPhase, readPhase, writePhase;
  logic [2:0] stepId;

  int cmpCnt = 0, errCnt = 0, cycles = 0;
  int loA = 0, hiA = 63, loR = 0, hiR = 63, loW = 0, hiW = 63, edgeE = 1;
  int expA = 0, expW = 0, expR = 0, expWr = 0;
  logic logClr = 1'b0;
  int logSeq, lastSid, loadCnt, capCnt, rdCnt, wrCnt, wrbCnt, badOrder, settleBad, stableCnt;
  logic prevReq;
  logic [5:0] prevPh;
  bit wrPend;

  always #10 clk = ~clk;

  link_train_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfgAddrEn(cfgAddrEn), .cfgSettle(cfgSettle),
    .retrainReq(retrainReq), .freqChange(freqChange), .refreshWin(refreshWin),
    .cmdReq(cmdReq), .cmdKind(cmdKind), .cmdAck(cmdAck), .resultPass(resultPass),
    .lateFlag(lateFlag), .phaseIdx(phaseIdx), .stepId(stepId), .addrPhase(addrPhase),
    .wckPhase(wckPhase), .readPhase(readPhase), .writePhase(writePhase),
    .done(done), .error(error)
  );

  function automatic logic inWin(input logic [5:0] p, input int lo, input int hi);
    return (int'(p) >= lo) && (int'(p) <= hi);
  endfunction

  assign resultPass = (stepId == 3'd1) ? inWin(phaseIdx, loA, hiA) :
                      (stepId == 3'd3) ? inWin(phaseIdx, loR, hiR) :
                      (stepId == 3'd4) ? inWin(phaseIdx, loW, hiW) : 1'b0;
  assign lateFlag = (int'(phaseIdx) >= edgeE);

  // Device model and monitor: acknowledge pulse, command log, settle check
  always @(negedge clk) begin
    logic ackNext;
    ackNext = rst_n && cmdReq && !cmdAck;
    if (!rst_n || logClr) begin
      logSeq = 0; lastSid = 0; loadCnt = 0; capCnt = 0; rdCnt = 0; wrCnt = 0;
      wrbCnt = 0; badOrder = 0; settleBad = 0; wrPend = 0;
    end else begin
      if (int'(stepId) != lastSid && stepId != 3'd0) logSeq = logSeq * 10 + int'(stepId);
      lastSid = int'(stepId);
      if (phaseIdx == prevPh) stableCnt++; else stableCnt = 1;
      if (cmdReq && !prevReq && cmdKind != 2'd1 && stableCnt < int'(cfgSettle) + 1) settleBad++;
      if (ackNext) begin
        case (stepId)
          3'd1: if (cmdKind == 2'd0) capCnt++; else badOrder++;
          3'd3: begin
            if (cmdKind == 2'd1) loadCnt++;
            else if (cmdKind == 2'd2) begin if (loadCnt == 0) badOrder++; rdCnt++; end
            else badOrder++;
          end
          3'd4: begin
            if (cmdKind == 2'd3) begin if (wrPend) badOrder++; wrPend = 1; wrCnt++; end
            else if (cmdKind == 2'd2) begin if (!wrPend) badOrder++; wrPend = 0; wrbCnt++; end
            else badOrder++;
          end
          default: badOrder++;
        endcase
      end
    end
    prevReq = cmdReq;
    prevPh  = phaseIdx;
    cmdAck <= ackNext;
  end

  always @(posedge clk) cycles++;

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    cmpCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic kick(input bit st, input bit rt, input bit fc);
    @(posedge clk); #5;
    logClr = 1'b1; start = st; retrainReq = rt; refreshWin = rt; freqChange = fc;
    @(posedge clk); #5;
    logClr = 1'b0; start = 1'b0; retrainReq = 1'b0; refreshWin = 1'b0;
  endtask

  task automatic waitEnd();
    int n = 0;
    while ((done || error) && n < 5) begin @(posedge clk); #5; n++; end
    n = 0;
    while (!done && !error && n < 30000) begin @(posedge clk); #5; n++; end
    if (n >= 30000) chkEq("R8", "training timeout", 0, 1);
  endtask

  task automatic setWin(input int la, ha, lr, hr, lw, hw, e);
    loA = la; hiA = ha; loR = lr; hiR = hr; loW = lw; hiW = hw; edgeE = e;
  endtask

  task automatic checkOk(input int seq, input bit aStep);
    chkEq("R8", "done", int'(done), 1);
    chkEq("R8", "error", int'(error), 0);
    chkEq("R2", "step order", logSeq, seq);
    chkEq("R3", "clock phase", int'(wckPhase), expW);
    chkEq("R4", "read phase", int'(readPhase), expR);
    chkEq("R4", "write phase", int'(writePhase), expWr);
    chkEq("R2", "address phase", int'(addrPhase), expA);
    chkEq("R6", "address captures", capCnt, aStep ? 64 : 0);
    chkEq("R6", "fifo preloads", loadCnt, 1);
    chkEq("R6", "read step fifo reads", rdCnt, 64);
    chkEq("R6", "write step writes", wrCnt, 64);
    chkEq("R6", "write step readbacks", wrbCnt, 64);
    chkEq("R6", "command order errors", badOrder, 0);
    chkEq("R7", "settle violations", settleBad, 0);
  endtask

  task automatic checkFail(input int seq);
    chkEq("R5", "error", int'(error), 1);
    chkEq("R5", "done", int'(done), 0);
    chkEq("R5", "step order at failure", logSeq, seq);
    repeat (20) @(posedge clk);
    #5;
    chkEq("R5", "no request after failure", int'(cmdReq), 0);
    chkEq("R5", "error held", int'(error), 1);
  endtask

  task automatic runOk(input bit aEn, input int s, la, ha, lr, hr, lw, hw, e);
    cfgAddrEn = aEn; cfgSettle = 8'(s);
    setWin(la, ha, lr, hr, lw, hw, e);
    if (aEn) expA = (la + ha) / 2;
    expW = e; expR = (lr + hr) / 2; expWr = (lw + hw) / 2;
    kick(1'b1, 1'b0, 1'b0);
    waitEnd();
    checkOk(aEn ? 1234 : 234, aEn);
  endtask

  task automatic runFail(input int lr, hr, lw, hw, e, seq);
    cfgAddrEn = 1'b0; cfgSettle = 8'd1;
    setWin(0, 63, lr, hr, lw, hw, e);
    kick(1'b1, 1'b0, 1'b0);
    waitEnd();
    checkFail(seq);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    chkEq("R1", "done", int'(done), 0);
    chkEq("R1", "error", int'(error), 0);
    chkEq("R1", "cmdReq", int'(cmdReq), 0);
    chkEq("R1", "stepId", int'(stepId), 0);
    chkEq("R1", "trained phases", int'(addrPhase) + int'(wckPhase) + int'(readPhase) + int'(writePhase), 0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    chkEq("R1", "idle after reset", int'(stepId), 0);

    // R2 R3 R4 R6 R7 R8: windows and settle counts swept arithmetically
    for (int k = 0; k < 4; k++)
      runOk(1'b1, k, k * 7, k * 7 + 10 + k, 5 + k * 9, 5 + k * 11, 20 + k, 63 - k, 1 + k * 20);
    // R4 boundaries: single-code windows at both ends, full window
    runOk(1'b0, 2, 0, 63, 0, 0, 63, 63, 63);
    runOk(1'b1, 0, 0, 63, 0, 63, 62, 63, 2);

    // R3 R5: no early-to-late transition, empty data windows
    runFail(0, 63, 0, 63, 0, 2);
    runFail(0, 63, 0, 63, 64, 2);
    runFail(10, 9, 0, 63, 5, 23);
    runFail(0, 63, 40, 39, 5, 234);

    // R10: start after failure clears error
    runOk(1'b1, 1, 3, 9, 12, 30, 8, 50, 17);

    // R9: retrain waits for the refresh window, then starts at read training
    setWin(3, 9, 20, 40, 30, 44, 33);
    expR = 30; expWr = 37;
    @(posedge clk); #5;
    retrainReq = 1'b1; refreshWin = 1'b0;
    repeat (10) @(posedge clk);
    #5;
    chkEq("R9", "done held without refresh window", int'(done), 1);
    chkEq("R9", "idle without refresh window", int'(stepId), 0);
    retrainReq = 1'b0;
    kick(1'b0, 1'b1, 1'b0);
    waitEnd();
    checkOk(34, 1'b0);

    // R9: frequency change retrains from clock alignment
    expW = 33;
    kick(1'b0, 1'b1, 1'b1);
    waitEnd();
    freqChange = 1'b0;
    checkOk(234, 1'b0);

    // R10: start and retrain together run the full sequence
    cfgAddrEn = 1'b1;
    setWin(50, 60, 1, 2, 4, 9, 45);
    expA = 55; expW = 45; expR = 1; expWr = 6;
    kick(1'b1, 1'b1, 1'b0);
    waitEnd();
    checkOk(1234, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    errCnt++;
    cmpCnt++;
    $display("FAIL R8 watchdog: actual %0d expected below %0d cycles", cycles, 190000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end

endmodule